// File: doc/BRIEF.md
# Differential PSK Carrier-Tracking Demodulator

This block recovers data from a differentially encoded BPSK or QPSK signal carried on a digitised IF stream. It takes one IF sample per clock. Each sample is reduced to one of three levels by a programmable dead-zone threshold. The reduced sample is then mixed with the cosine and the negated sine of an internal numerically controlled oscillator. The in-phase and quadrature products are summed in two integrate-and-dump accumulators. An external strobe, one per symbol, captures both sums and restarts them from zero.

Every accepted strobe starts a short symbol-processing pass. The captured pair is multiplied by the conjugate of the previous captured pair, and the signs of that product give one bit (DBPSK) or a Gray-coded dibit (DQPSK). The same pass forms a phase error without any arctangent. The error feeds a proportional-plus-integral loop filter with shift gains, and the filtered value is added to the nominal frequency word. The sum is clamped to the legal range so that the oscillator is always steered and never wraps. The configuration inputs select the modulation, the two gain shifts, the loop enable and the nominal IF word.

Top module: `dpsk_demod`

## Requirements
- R1: A sample x is quantised against the threshold T to +1 when x > T, to -1 when x < -T, and to 0 otherwise, so samples with |x| <= T add nothing to either accumulator.
- R2: Each strobe captures the sums of all products since the previous strobe, and the accumulators restart from zero, so one symbol's samples never leak into the next decision.
- R3: In DBPSK mode (cfg_qpsk = 0) dec_bits[0] is 1 exactly when the real part of current·conj(previous) is negative, and dec_bits[1] is 0.
- R4: In DQPSK mode (cfg_qpsk = 1) dec_bits[1] is 1 when that real part is negative and dec_bits[0] is 1 when the imaginary part is negative. A value of zero counts as non-negative, so a 0° change gives 00 and a 180° change gives 10.
- R5: dec_valid is high for exactly one clock, in the third cycle after the clock edge that samples an accepted strobe.
- R6: A strobe sampled while a pass is still running (the two edges after an accepted strobe) is not decided and does not replace the previous symbol. It still clears the accumulators, and overrun pulses for one clock on the next cycle.
- R7: With cfg_loop_en = 0 the integrator and the correction are held at zero, and freq_out equals cfg_freq one cycle later.
- R8: With the loop enabled, freq_out = clamp(cfg_freq + (e >>> cfg_kp) + integ, 0, 2^24-1), where integ accumulates e >>> cfg_ki once per pass. A positive error raises the frequency. The mixer forms I = q·cos and Q = -q·sin, and the oscillator phase starts at zero after reset.
- R9: The phase error e is I·sgn(Q) - Q·sgn(I) in DQPSK mode and I·Q in DBPSK mode, with sgn(0) = +1, so a symbol of all-zero quantised samples leaves freq_out unchanged.
- R10: The previous symbol is zero after reset, so the first decision after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sample | input | 8 | Signed IF sample, one per clock |
| cfg_thresh | input | 8 | Dead-zone threshold magnitude for the three-level quantiser |
| cfg_qpsk | input | 1 | 1 = DQPSK, 0 = DBPSK |
| cfg_freq | input | 24 | Nominal oscillator frequency word (phase step per clock) |
| cfg_kp | input | 5 | Right-shift applied to the error for the proportional path |
| cfg_ki | input | 5 | Right-shift applied to the error for the integral path |
| cfg_loop_en | input | 1 | Closes the carrier loop when high |
| dump | input | 1 | End-of-symbol strobe |
| dec_valid | output | 1 | One-clock strobe marking new decision bits |
| dec_bits | output | 2 | Decided bit (DBPSK, bit 0) or dibit (DQPSK) |
| overrun | output | 1 | One-clock pulse for a strobe that arrived during a pass |
| freq_out | output | 24 | Frequency word currently steering the oscillator |

## Verification
The bench uses the default parameters: 8-bit samples, a 24-bit phase accumulator, an 8-entry quarter table and 16-bit accumulators. With the nominal word at zero the oscillator phase stays fixed, so the decision signs depend only on the sign of each symbol's quantised sum, and the bench predicts them exactly. A 24-bit word with a nominal value of 64 or 2^24-64 keeps the phase just on either side of zero. That makes the sign of the error known, so both clamp limits can be reached in a single symbol. Sixteen-sample symbols keep the sums well inside the accumulator range, and the threshold sits at 20 so that samples of ±20 and ±21 probe the dead-zone edge.

// File: rtl/dpsk_pkg.sv
// Package: shared types for the differential PSK demodulator.
// Assumes: nothing beyond IEEE 1800-2017.
package dpsk_pkg;
    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_CALC = 2'd1,
        SP_LOOP = 2'd2
    } sp_state_t;
endpackage

// File: rtl/dpsk_nco.sv
// Numerically controlled oscillator: a PW-bit phase accumulator whose top
// 2+QB bits address a quarter-wave table (parabolic sine fit sampled at
// bin centres), giving registered cosine and sine outputs.
// Assumes: freq is the phase step per clock; phase is zero after reset.
module dpsk_nco #(
    parameter int PW = 24,
    parameter int QB = 3,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        freq,
    output logic signed [AW-1:0] cos_o,
    output logic signed [AW-1:0] sin_o
);
    localparam int QN   = 1 << QB;
    localparam int AMAX = (1 << (AW - 1)) - 1;

    // Table entry k: AMAX * 4x(1-x) with x = (2k+1)/(4*QN), always positive.
    function automatic logic signed [AW-1:0] qtab(input logic [QB-1:0] k);
        int m;
        m = 2 * int'(k) + 1;
        return AW'((AMAX * m * (4 * QN - m)) / (4 * QN * QN));
    endfunction

    logic [PW-1:0]        phase;
    logic [1:0]           quad;
    logic [QB-1:0]        idx;
    logic signed [AW-1:0] t_fwd;
    logic signed [AW-1:0] t_rev;

    assign quad  = phase[PW-1 -: 2];
    assign idx   = phase[PW-3 -: QB];
    assign t_fwd = qtab(idx);
    assign t_rev = qtab(~idx);

    // Phase accumulation, one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + freq;
    end

    // Quadrant folding of the quarter table into cosine and sine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            case (quad)
                2'd0: begin sin_o <=  t_fwd; cos_o <=  t_rev; end
                2'd1: begin sin_o <=  t_rev; cos_o <= -t_fwd; end
                2'd2: begin sin_o <= -t_fwd; cos_o <= -t_rev; end
                default: begin sin_o <= -t_rev; cos_o <= t_fwd; end
            endcase
        end
    end
endmodule

// File: rtl/dpsk_mix_iad.sv
// Three-level quantiser, complex mixer and integrate-and-dump pair.
// I = q*cos, Q = -q*sin. On dump the running sums plus the current product
// are captured into the hold registers and the accumulators restart at zero.
// Assumes: thresh is a non-negative magnitude; table amplitude below 2^(AW-1).
module dpsk_mix_iad #(
    parameter int SW   = 8,
    parameter int AW   = 8,
    parameter int ACCW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [SW-1:0]   rx,
    input  logic [SW-1:0]          thresh,
    input  logic signed [AW-1:0]   cos_i,
    input  logic signed [AW-1:0]   sin_i,
    input  logic                   dump,
    output logic signed [ACCW-1:0] hold_i,
    output logic signed [ACCW-1:0] hold_q
);
    logic signed [SW:0]    rx_x;
    logic signed [SW:0]    thr_x;
    logic                  q_pos;
    logic                  q_neg;
    logic signed [AW-1:0]  prod_i;
    logic signed [AW-1:0]  prod_q;
    logic signed [ACCW-1:0] ext_i;
    logic signed [ACCW-1:0] ext_q;
    logic signed [ACCW-1:0] acc_i;
    logic signed [ACCW-1:0] acc_q;

    assign rx_x  = {rx[SW-1], rx};
    assign thr_x = {1'b0, thresh};

    // Register the three-level decision of the incoming sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pos <= 1'b0;
            q_neg <= 1'b0;
        end else begin
            q_pos <= (rx_x > thr_x);
            q_neg <= (rx_x < -thr_x);
        end
    end

    // Mixer: multiply a three-level value by the oscillator outputs.
    always_comb begin
        prod_i = '0;
        prod_q = '0;
        if (q_pos) begin
            prod_i = cos_i;
            prod_q = -sin_i;
        end else if (q_neg) begin
            prod_i = -cos_i;
            prod_q = sin_i;
        end
    end

    assign ext_i = {{(ACCW-AW){prod_i[AW-1]}}, prod_i};
    assign ext_q = {{(ACCW-AW){prod_q[AW-1]}}, prod_q};

    // Integrate every clock; on dump capture the total and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_i  <= '0;
            acc_q  <= '0;
            hold_i <= '0;
            hold_q <= '0;
        end else if (dump) begin
            hold_i <= acc_i + ext_i;
            hold_q <= acc_q + ext_q;
            acc_i  <= '0;
            acc_q  <= '0;
        end else begin
            acc_i  <= acc_i + ext_i;
            acc_q  <= acc_q + ext_q;
        end
    end
endmodule

// File: rtl/dpsk_symproc.sv
// Symbol processor: per accepted dump, forms current*conj(previous) for the
// differential decision and a sign-based phase error, then runs a PI loop
// filter with shift gains. The frequency word is nominal plus correction,
// clamped to [0, 2^PW-1] and registered every clock.
// Assumes: dump is a one-cycle strobe; hold_* are valid the edge after dump.
module dpsk_symproc
    import dpsk_pkg::*;
#(
    parameter int ACCW = 16,
    parameter int PW   = 24,
    parameter int SHW  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dump,
    input  logic signed [ACCW-1:0] hold_i,
    input  logic signed [ACCW-1:0] hold_q,
    input  logic                   qpsk,
    input  logic                   loop_en,
    input  logic [SHW-1:0]         kp,
    input  logic [SHW-1:0]         ki,
    input  logic [PW-1:0]          nominal,
    output logic                   dec_valid,
    output logic [1:0]             dec_bits,
    output logic                   overrun,
    output logic [PW-1:0]          freq_out
);
    localparam int EW  = 2 * ACCW + 1;
    localparam int LW  = ((EW > PW + 2) ? EW : PW + 2) + 2;
    localparam int M   = 2 * ACCW - 1;
    localparam logic signed [LW-1:0] IMAX = {{(LW-PW-1){1'b0}}, 1'b1, {PW{1'b0}}};
    localparam logic signed [LW-1:0] IMIN = -IMAX;
    localparam logic signed [LW-1:0] FMAX = {{(LW-PW){1'b0}}, {PW{1'b1}}};

    sp_state_t              state;
    logic signed [ACCW-1:0] cur_i, cur_q, prev_i, prev_q;
    logic signed [2*ACCW-1:0] p_ii, p_qq, p_qi, p_iq, p_cc;
    logic [EW-1:0]          re_c, im_c, err_c;
    logic signed [ACCW:0]   ci_x, cq_x, qa, qb;
    logic [ACCW+1:0]        qerr;
    logic                   re_neg, im_neg;
    logic signed [EW-1:0]   err_r;
    logic signed [LW-1:0]   err_w, pterm, iterm, isum, icl, integ, corr, fsum;

    // Conjugate product of the newly captured pair with the previous one.
    assign p_ii = hold_i * prev_i;
    assign p_qq = hold_q * prev_q;
    assign p_qi = hold_q * prev_i;
    assign p_iq = hold_i * prev_q;
    assign re_c = {p_ii[M], p_ii} + {p_qq[M], p_qq};
    assign im_c = {p_qi[M], p_qi} - {p_iq[M], p_iq};

    // Phase error: sign-based for QPSK, plain I*Q for BPSK.
    assign ci_x  = {hold_i[ACCW-1], hold_i};
    assign cq_x  = {hold_q[ACCW-1], hold_q};
    assign qa    = hold_q[ACCW-1] ? -ci_x : ci_x;
    assign qb    = hold_i[ACCW-1] ? -cq_x : cq_x;
    assign qerr  = {qa[ACCW], qa} - {qb[ACCW], qb};
    assign p_cc  = hold_i * hold_q;
    assign err_c = qpsk ? {{(EW-ACCW-2){qerr[ACCW+1]}}, qerr} : {p_cc[M], p_cc};

    // Loop filter terms and integrator clamp.
    assign err_w = $signed({{(LW-EW){err_r[EW-1]}}, err_r});
    assign pterm = err_w >>> kp;
    assign iterm = err_w >>> ki;
    assign isum  = integ + iterm;
    assign icl   = (isum > IMAX) ? IMAX : ((isum < IMIN) ? IMIN : isum);
    assign fsum  = $signed({{(LW-PW){1'b0}}, nominal}) + corr;

    // Pass sequencing, decision and loop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SP_IDLE;
            cur_i     <= '0;
            cur_q     <= '0;
            prev_i    <= '0;
            prev_q    <= '0;
            re_neg    <= 1'b0;
            im_neg    <= 1'b0;
            err_r     <= '0;
            dec_valid <= 1'b0;
            dec_bits  <= 2'b00;
            overrun   <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            overrun   <= dump && (state != SP_IDLE);
            case (state)
                SP_IDLE: if (dump) state <= SP_CALC;
                SP_CALC: begin
                    cur_i  <= hold_i;
                    cur_q  <= hold_q;
                    re_neg <= re_c[EW-1];
                    im_neg <= im_c[EW-1];
                    err_r  <= $signed(err_c);
                    state  <= SP_LOOP;
                end
                default: begin
                    prev_i    <= cur_i;
                    prev_q    <= cur_q;
                    dec_bits  <= qpsk ? {re_neg, im_neg} : {1'b0, re_neg};
                    dec_valid <= 1'b1;
                    state     <= SP_IDLE;
                end
            endcase
        end
    end

    // Integrator and correction, updated once per pass while the loop is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || !loop_en) begin
            integ <= '0;
            corr  <= '0;
        end else if (state == SP_LOOP) begin
            integ <= icl;
            corr  <= icl + pterm;
        end
    end

    // Clamped frequency word for the oscillator.
    always_ff @(posedge clk) begin
        if (!rst_n)            freq_out <= '0;
        else if (fsum < 0)     freq_out <= '0;
        else if (fsum > FMAX)  freq_out <= '1;
        else                   freq_out <= fsum[PW-1:0];
    end
endmodule

// File: rtl/dpsk_demod.sv
// Top of the differential PSK carrier-tracking demodulator: oscillator,
// quantiser/mixer/integrate-and-dump, and symbol processor closing the loop.
// Assumes: one IF sample per clock; dump marks the end of each symbol.
module dpsk_demod #(
    parameter int SW   = 8,
    parameter int PW   = 24,
    parameter int QB   = 3,
    parameter int AW   = 8,
    parameter int ACCW = 16,
    parameter int SHW  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [SW-1:0] rx_sample,
    input  logic [SW-1:0]        cfg_thresh,
    input  logic                 cfg_qpsk,
    input  logic [PW-1:0]        cfg_freq,
    input  logic [SHW-1:0]       cfg_kp,
    input  logic [SHW-1:0]       cfg_ki,
    input  logic                 cfg_loop_en,
    input  logic                 dump,
    output logic                 dec_valid,
    output logic [1:0]           dec_bits,
    output logic                 overrun,
    output logic [PW-1:0]        freq_out
);
    logic signed [AW-1:0]   nco_cos;
    logic signed [AW-1:0]   nco_sin;
    logic signed [ACCW-1:0] sym_i;
    logic signed [ACCW-1:0] sym_q;

    dpsk_nco #(.PW(PW), .QB(QB), .AW(AW)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .freq  (freq_out),
        .cos_o (nco_cos),
        .sin_o (nco_sin)
    );

    dpsk_mix_iad #(.SW(SW), .AW(AW), .ACCW(ACCW)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx     (rx_sample),
        .thresh (cfg_thresh),
        .cos_i  (nco_cos),
        .sin_i  (nco_sin),
        .dump   (dump),
        .hold_i (sym_i),
        .hold_q (sym_q)
    );

    dpsk_symproc #(.ACCW(ACCW), .PW(PW), .SHW(SHW)) u_sym (
        .clk       (clk),
        .rst_n     (rst_n),
        .dump      (dump),
        .hold_i    (sym_i),
        .hold_q    (sym_q),
        .qpsk      (cfg_qpsk),
        .loop_en   (cfg_loop_en),
        .kp        (cfg_kp),
        .ki        (cfg_ki),
        .nominal   (cfg_freq),
        .dec_valid (dec_valid),
        .dec_bits  (dec_bits),
        .overrun   (overrun),
        .freq_out  (freq_out)
    );
endmodule

// File: rtl/dpsk_demod_chk.sv
// Checker: timing and mode properties of the demodulator ports.
// Assumes: bound to dpsk_demod; all properties disabled during reset.
module dpsk_demod_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dump,
    input logic          cfg_qpsk,
    input logic          cfg_loop_en,
    input logic [PW-1:0] cfg_freq,
    input logic          dec_valid,
    input logic [1:0]    dec_bits,
    input logic          overrun,
    input logic [PW-1:0] freq_out
);
    logic [1:0] cyc;

    // Cycles since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r5_valid_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(dump, 3));

    a_r6_overrun_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(dump));

    a_r3_dbpsk_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(cfg_qpsk)) |-> (dec_bits[1] == 1'b0));

    a_r7_open_loop_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && !$past(cfg_loop_en, 2) && !$past(cfg_loop_en))
        |-> (freq_out == $past(cfg_freq)));
endmodule

bind dpsk_demod dpsk_demod_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dump        (dump),
    .cfg_qpsk    (cfg_qpsk),
    .cfg_loop_en (cfg_loop_en),
    .cfg_freq    (cfg_freq),
    .dec_valid   (dec_valid),
    .dec_bits    (dec_bits),
    .overrun     (overrun),
    .freq_out    (freq_out)
);

// File: tb/test_dpsk_demod.sv
// Scoreboard bench: the symbol driver pushes expected decisions, a monitor
// pops and compares them on each dec_valid.
module test_dpsk_demod;
    localparam int SW = 8;
    localparam int PW = 24;
    localparam int THR = 20;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic signed [SW-1:0] rx_sample;
    logic [SW-1:0]        cfg_thresh;
    logic                 cfg_qpsk;
    logic [PW-1:0]        cfg_freq;
    logic [4:0]           cfg_kp;
    logic [4:0]           cfg_ki;
    logic                 cfg_loop_en;
    logic                 dump;
    logic                 dec_valid;
    logic [1:0]           dec_bits;
    logic                 overrun;
    logic [PW-1:0]        freq_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    n_ovr   = 0;
    int    prev_s  = 0;
    logic [1:0] exp_bits[$];
    string      exp_req[$];

    always #10 clk = ~clk;

    dpsk_demod i_dpsk_demod (
        .clk(clk), .rst_n(rst_n), .rx_sample(rx_sample), .cfg_thresh(cfg_thresh),
        .cfg_qpsk(cfg_qpsk), .cfg_freq(cfg_freq), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki),
        .cfg_loop_en(cfg_loop_en), .dump(dump), .dec_valid(dec_valid),
        .dec_bits(dec_bits), .overrun(overrun), .freq_out(freq_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qlev(input int v);
        return (v > THR) ? 1 : ((v < -THR) ? -1 : 0);
    endfunction

    // Monitor: compare each decision with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && overrun) n_ovr++;
        if (rst_n && dec_valid) begin
            if (exp_bits.size() == 0) begin
                chk("R5 unexpected dec_valid", 1, 0);
            end else begin
                chk(exp_req.pop_front(), longint'(dec_bits), longint'(exp_bits.pop_front()));
            end
        end
    end

    task automatic do_reset(input logic [PW-1:0] nom, input logic loop_on, input logic qp);
        rst_n = 1'b0; dump = 1'b0; rx_sample = '0; cfg_thresh = SW'(THR);
        cfg_freq = nom; cfg_loop_en = loop_on; cfg_qpsk = qp; cfg_kp = '0; cfg_ki = '0;
        prev_s = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic drive(input int n, input int v);
        for (int k = 0; k < n; k++) begin
            rx_sample = SW'(v);
            @(negedge clk);
        end
    endtask

    // One symbol: n1 samples of v1, n2 of v2, zero gap, dump, idle.
    task automatic send_sym(input string req, input int n1, input int v1,
                            input int n2, input int v2, input logic push);
        int s;
        logic neg;
        s   = n1 * qlev(v1) + n2 * qlev(v2);
        neg = (s * prev_s) < 0;
        if (push) begin
            exp_bits.push_back(cfg_qpsk ? {neg, 1'b0} : {1'b0, neg});
            exp_req.push_back(req);
        end
        prev_s = s;
        drive(n1, v1);
        drive(n2, v2);
        drive(2, 0);
        dump = 1'b1;
        @(negedge clk);
        dump = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset('0, 1'b0, 1'b0);
        chk("R5 reset dec_valid", longint'(dec_valid), 0);
        chk("R6 reset overrun", longint'(overrun), 0);
        chk("R7 reset freq_out", longint'(freq_out), 0);

        // DBPSK with the oscillator frozen at phase zero.
        send_sym("R10 first decision", 16, 50, 0, 0, 1'b1);
        send_sym("R3 same sign", 16, 50, 0, 0, 1'b1);
        send_sym("R3 sign flip", 16, -50, 0, 0, 1'b1);
        send_sym("R2 negative kept", 16, -50, 0, 0, 1'b1);
        send_sym("R2 back positive", 16, 60, 0, 0, 1'b1);
        send_sym("R2 mixed positive sum", 10, 50, 6, -50, 1'b1);
        send_sym("R1 threshold edge 20", 16, 20, 0, 0, 1'b1);
        send_sym("R1 after zero symbol", 16, -21, 0, 0, 1'b1);
        send_sym("R1 negative edge -20", 8, -20, 8, -50, 1'b1);
        send_sym("R2 mixed negative sum", 5, 50, 11, -40, 1'b1);
        send_sym("R3 flip to positive", 16, 30, 0, 0, 1'b1);

        // DQPSK decisions on 180 and 0 degree changes.
        cfg_qpsk = 1'b1;
        send_sym("R4 180 degree", 16, -50, 0, 0, 1'b1);
        send_sym("R4 0 degree", 16, -50, 0, 0, 1'b1);
        cfg_qpsk = 1'b0;

        // Overrun: second strobe two edges after the first is dropped.
        begin
            int ov0;
            ov0 = n_ovr;
            exp_bits.push_back(2'b01);
            exp_req.push_back("R6 accepted before overrun");
            prev_s = 16;
            drive(16, 50);
            drive(2, 0);
            dump = 1'b1; @(negedge clk);
            dump = 1'b0; @(negedge clk);
            dump = 1'b1; @(negedge clk);
            dump = 1'b0;
            repeat (6) @(negedge clk);
            chk("R6 overrun pulses", longint'(n_ovr - ov0), 1);
            send_sym("R6 previous kept through overrun", 16, -50, 0, 0, 1'b1);
        end
        chk("R5 scoreboard drained", longint'(exp_bits.size()), 0);

        // Zero error leaves the frequency word alone.
        do_reset(24'd64, 1'b1, 1'b1);
        send_sym("R10 first after reset", 16, 15, 0, 0, 1'b1);
        chk("R9 zero error freq", longint'(freq_out), 64);

        // Negative error near phase zero clamps at the bottom.
        do_reset(24'd64, 1'b1, 1'b1);
        send_sym("R10 first after reset", 16, 50, 0, 0, 1'b1);
        chk("R8 clamp low", longint'(freq_out), 0);

        // Positive error just below phase zero clamps at the top.
        do_reset(24'hFFFFC0, 1'b1, 1'b1);
        send_sym("R10 first after reset", 16, 50, 0, 0, 1'b1);
        chk("R8 clamp high", longint'(freq_out), longint'(24'hFFFFFF));

        // Opening the loop restores the nominal word.
        cfg_loop_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 open loop nominal", longint'(freq_out), longint'(24'hFFFFC0));
        chk("R5 scoreboard drained at end", longint'(exp_bits.size()), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule